// File: doc/BRIEF.md
# Truth-Table Configurable Adder-Logic Unit

This block is an 8-bit arithmetic and logic unit. A single 4-bit code, used as a truth table, selects any two-input bitwise function of the operands. Each result bit of the logic stage is read out of that code, with the matching bits of A and B acting as the read address. The logic result then feeds one input of an adder. The other adder input is either operand A or zero, chosen by an enable bit. A carry-in completes the sum.

A controller chooses the code, the A enable and the carry-in to get a wide range of operations:

- a plain bitwise result (A disabled, carry-in low),
- addition,
- subtraction through the complemented B operand and a carry-in of one,
- increment,
- doubling,
- constants.

The sum, the carry out of the top bit and a flag that marks an all-zero sum are captured in output registers on every rising clock edge. A synchronous active-high reset clears those registers.

Top module: `tt_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the edge sets `result` to 0, `carry_out` to 0 and `zero_flag` to 1.
- R2: Logic stage bit i equals `tt_code[{op_a[i], op_b[i]}]`. Code bit 0 is selected for a=0,b=0, bit 1 for a=0,b=1, bit 2 for a=1,b=0 and bit 3 for a=1,b=1. So 4'b1000 is AND, 4'b1110 is OR, 4'b0110 is XOR, 4'b1010 passes B, 4'b1100 passes A, 4'b0101 is NOT B and 4'b0011 is NOT A.
- R3: With `a_keep` low, operand A adds nothing, and `result` = (logic stage + `carry_in`) mod 256.
- R4: With `a_keep` high, `result` = (A + logic stage + `carry_in`) mod 256.
- R5: `carry_out` is bit 8 of the 9-bit sum of the two adder inputs and `carry_in`.
- R6: `zero_flag` is 1 exactly when all 8 bits of `result` are 0.
- R7: With `a_keep`=1, `tt_code`=4'b0101 and `carry_in`=1, `result` is A−B mod 256, and `carry_out` is 1 exactly when A ≥ B (unsigned).
- R8: The outputs change only at a rising clock edge. They show the inputs present at the most recent rising edge, so the latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the outputs update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 8 | Operand A |
| op_b | input | 8 | Operand B |
| tt_code | input | 4 | Truth-table code for the logic stage |
| a_keep | input | 1 | 1 routes A to the adder, 0 routes zero |
| carry_in | input | 1 | Carry into the adder's least significant bit |
| result | output | 8 | Registered sum |
| carry_out | output | 1 | Registered carry from bit 7 |
| zero_flag | output | 1 | Registered all-zero indication for the sum |

## Verification
The bench goes after the truth-table bit order. Swapping the A and B select bits would turn the "pass A" and "pass B" codes into each other and break NOT A and NOT B. It drives operands 0x00, 0xFF and 0x80 through all sixteen codes, with A gated on and off and carry-in at both values. A dropped carry-in or an ungated A would show up as an off-by-one sum or as A leaking into the logic-only results.

Subtraction is checked with A both above and below B, because a wrong carry polarity breaks the borrow meaning. The 0x80+0x80 and 0xFF+1 cases wrap to zero, which catches a zero flag taken before truncation and a carry taken from the wrong bit. The bench also checks that a change at the inputs reaches the outputs only after the next edge.

// File: rtl/tt_alu_pkg.sv
package tt_alu_pkg;
  localparam int unsigned TT_BITS = 4;

  typedef enum logic [TT_BITS-1:0] {
    TT_ZERO   = 4'b0000,
    TT_AND    = 4'b1000,
    TT_XOR    = 4'b0110,
    TT_OR     = 4'b1110,
    TT_PASS_B = 4'b1010,
    TT_NOT_B  = 4'b0101,
    TT_PASS_A = 4'b1100,
    TT_NOT_A  = 4'b0011,
    TT_ONES   = 4'b1111
  } tt_code_e;
endpackage

// File: rtl/tt_alu_logic.sv
module tt_alu_logic
  import tt_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [TT_BITS-1:0] code_i,
  output logic [DATA_W-1:0]  f_o
);
  // One 4:1 selector per bit: operand bits address the truth table.
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    logic [1:0] sel;
    assign sel      = {a_i[gi], b_i[gi]};
    assign f_o[gi]  = code_i[sel];
  end

  always_comb begin
    if (code_i == TT_ZERO) begin
      p_allzero_r2: assert (f_o == '0);
    end
    if (code_i == TT_ONES) begin
      p_allone_r2: assert (f_o == '1);
    end
  end
endmodule

// File: rtl/tt_alu_gate.sv
module tt_alu_gate #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              en_i,
  output logic [DATA_W-1:0] y_o
);
  assign y_o = a_i & {DATA_W{en_i}};
endmodule

// File: rtl/tt_alu_adder.sv
module tt_alu_adder #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);
  localparam int unsigned SUM_W = DATA_W + 1;

  logic [SUM_W-1:0] full;
  assign full   = {1'b0, x_i} + {1'b0, y_i} + {{DATA_W{1'b0}}, cin_i};
  assign sum_o  = full[DATA_W-1:0];
  assign cout_o = full[DATA_W];

  // A wrapped sum can never exceed either addend.
  always_comb begin
    if (cout_o) begin
      p_carry_wrap_r5: assert (sum_o <= x_i && sum_o <= y_i);
    end else begin
      p_carry_none_r5: assert (sum_o >= x_i && sum_o >= y_i);
    end
  end
endmodule

// File: rtl/tt_alu.sv
module tt_alu
  import tt_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic [TT_BITS-1:0]  tt_code,
  input  logic                a_keep,
  input  logic                carry_in,
  output logic [DATA_W-1:0]   result,
  output logic                carry_out,
  output logic                zero_flag
);
  logic [DATA_W-1:0] logic_val;
  logic [DATA_W-1:0] a_gated;
  logic [DATA_W-1:0] sum_val;
  logic              sum_co;

  tt_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i    (op_a),
    .b_i    (op_b),
    .code_i (tt_code),
    .f_o    (logic_val)
  );

  tt_alu_gate #(.DATA_W(DATA_W)) u_gate (
    .a_i  (op_a),
    .en_i (a_keep),
    .y_o  (a_gated)
  );

  tt_alu_adder #(.DATA_W(DATA_W)) u_add (
    .x_i    (a_gated),
    .y_i    (logic_val),
    .cin_i  (carry_in),
    .sum_o  (sum_val),
    .cout_o (sum_co)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      zero_flag <= 1'b1;
    end else begin
      result    <= sum_val;
      carry_out <= sum_co;
      zero_flag <= ~|sum_val;
    end
  end

  p_zero_r6: assert property (@(posedge clk) disable iff (rst)
    zero_flag == (result == '0));

  p_sub_r7: assert property (@(posedge clk) disable iff (rst)
    (a_keep && tt_code == TT_NOT_B && carry_in) |=>
      (result == DATA_W'($past(op_a) - $past(op_b)) &&
       carry_out == ($past(op_a) >= $past(op_b))));
endmodule

// File: tb/tt_alu_bench.sv
module tt_alu_bench;
  localparam int unsigned W = 8;
  localparam int unsigned NVEC = 10;

  // {a, b, code, keep, cin, exp_result, exp_carry}
  localparam logic [30:0] VEC [NVEC] = '{
    {8'hF0, 8'h3C, 4'b1000, 1'b0, 1'b0, 8'h30, 1'b0},
    {8'hF0, 8'h3C, 4'b1110, 1'b0, 1'b0, 8'hFC, 1'b0},
    {8'hF0, 8'h3C, 4'b0110, 1'b0, 1'b0, 8'hCC, 1'b0},
    {8'h80, 8'h80, 4'b1010, 1'b1, 1'b0, 8'h00, 1'b1},
    {8'h05, 8'h03, 4'b0101, 1'b1, 1'b1, 8'h02, 1'b1},
    {8'h03, 8'h05, 4'b0101, 1'b1, 1'b1, 8'hFE, 1'b0},
    {8'hFF, 8'h12, 4'b0011, 1'b0, 1'b0, 8'h00, 1'b0},
    {8'hFF, 8'h00, 4'b0000, 1'b1, 1'b1, 8'h00, 1'b1},
    {8'h00, 8'h00, 4'b1111, 1'b0, 1'b1, 8'h00, 1'b1},
    {8'h81, 8'h44, 4'b1100, 1'b1, 1'b0, 8'h02, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [3:0]   tt_code = '0;
  logic         a_keep = 1'b0;
  logic         carry_in = 1'b0;
  logic [W-1:0] result;
  logic         carry_out;
  logic         zero_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tt_alu #(.DATA_W(W)) u_tt_alu (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .tt_code(tt_code),
    .a_keep(a_keep), .carry_in(carry_in),
    .result(result), .carry_out(carry_out), .zero_flag(zero_flag)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [8:0] model(input logic [7:0] a, input logic [7:0] b,
                                       input logic [3:0] c, input logic k,
                                       input logic ci);
    logic [7:0] f;
    for (int i = 0; i < 8; i++) f[i] = c[{a[i], b[i]}];
    return {1'b0, (k ? a : 8'h00)} + {1'b0, f} + {8'h00, ci};
  endfunction

  task automatic drive(input logic [7:0] a, input logic [7:0] b,
                       input logic [3:0] c, input logic k, input logic ci);
    @(negedge clk);
    op_a = a; op_b = b; tt_code = c; a_keep = k; carry_in = ci;
    @(negedge clk);
  endtask

  task automatic run_model(input string req, input logic [7:0] a,
                           input logic [7:0] b, input logic [3:0] c,
                           input logic k, input logic ci);
    logic [8:0] e;
    e = model(a, b, c, k, ci);
    drive(a, b, c, k, ci);
    chk(req, int'(result), int'(e[7:0]));
    chk("R5", int'(carry_out), int'(e[8]));
    chk("R6", int'(zero_flag), int'(e[7:0] == 8'h00));
  endtask

  initial begin
    logic [7:0] corner [3];
    corner[0] = 8'h00; corner[1] = 8'hFF; corner[2] = 8'h80;

    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1", int'(result), 0);
    chk("R1", int'(carry_out), 0);
    chk("R1", int'(zero_flag), 1);
    rst = 1'b0;

    // Table of hand-computed vectors (R2, R3, R4, R7)
    for (int v = 0; v < NVEC; v++) begin
      drive(VEC[v][30:23], VEC[v][22:15], VEC[v][14:11], VEC[v][10], VEC[v][9]);
      chk("R2_R4_R7 result", int'(result), int'(VEC[v][8:1]));
      chk("R5 carry", int'(carry_out), int'(VEC[v][0]));
      chk("R6 zero", int'(zero_flag), int'(VEC[v][8:1] == 8'h00));
    end

    // Corner operands through every code, gate and carry-in setting
    for (int ia = 0; ia < 3; ia++)
      for (int ib = 0; ib < 3; ib++)
        for (int c = 0; c < 16; c++)
          for (int m = 0; m < 4; m++)
            run_model(m[1] ? "R4" : "R3", corner[ia], corner[ib], 4'(c),
                      m[1], m[0]);

    // R7: subtraction on random operands, borrow meaning of carry
    for (int n = 0; n < 100; n++) begin
      logic [7:0] a, b;
      a = 8'($urandom); b = 8'($urandom);
      drive(a, b, 4'b0101, 1'b1, 1'b1);
      chk("R7 diff", int'(result), int'(8'(a - b)));
      chk("R7 borrow", int'(carry_out), int'(a >= b));
    end

    // R2/R4 random
    for (int n = 0; n < 200; n++)
      run_model("R2", 8'($urandom), 8'($urandom), 4'($urandom),
                1'($urandom), 1'($urandom));

    // R8: input change is not visible before the next edge
    drive(8'h12, 8'h34, 4'b1010, 1'b1, 1'b0);
    chk("R8 settled", int'(result), 'h46);
    @(posedge clk); #2;
    op_a = 8'h01; op_b = 8'h01; carry_in = 1'b1;
    #2;
    chk("R8 hold", int'(result), 'h46);
    @(negedge clk);
    chk("R8 hold edge", int'(result), 'h46);
    @(posedge clk); #1;
    chk("R8 update", int'(result), 'h03);

    // R1: reset in mid-run overrides a nonzero sum
    @(negedge clk);
    op_a = 8'hFF; op_b = 8'h01; tt_code = 4'b1010; a_keep = 1'b1; carry_in = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid result", int'(result), 0);
    chk("R1 mid carry", int'(carry_out), 0);
    chk("R1 mid zero", int'(zero_flag), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R5 after reset", int'(carry_out), 1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule